// File: doc/BRIEF.md
# Byte-Lane Parity and Bus Fault Escalation Unit

This unit sits between a processor core and its system bus. On the outgoing side it derives one odd-parity bit for each byte of the write data, so that write data always leaves with correct parity. On the incoming side it watches two independent read data buses. On each accepted beat of a bus whose check enable is set, it compares the received parity bits against the data.

A read parity error on an enabled bus has the same effect as the external fault input. The unit stalls the current transaction and, depending on two control bits, either requests a recoverable machine check, stops the machine for good (checkstop), or only stalls. The stall lasts until an interrupt acknowledge arrives. A checkstop can only be left through reset. Sticky status bits record which read bus and which byte lanes produced parity errors.

Each read bus is a valid/ready stream. A beat transfers in a cycle where both valid and ready are high. Ready is withdrawn for as long as the unit is stalled. While valid is high and ready is low, the source must hold data and parity steady. The write path is combinational and carries no handshake.

Top module: `bytepar_fault_unit`

## Requirements
- R1: For every byte lane i, wr_par[i] makes the eight bits wr_data[8i+7:8i] together with wr_par[i] contain an odd number of ones.
- R2: On a beat accepted on read bus 0 with rd_chk_en[0]=1, a byte whose eight data bits plus its parity bit hold an even number of ones is a parity error. The unit treats it exactly like an asserted fault_in.
- R3: Each read bus is checked only when its own bit is set (bit 0 for bus 0, bit 1 for bus 1). A parity error on a disabled bus causes no stall and no status change.
- R4: A fault event (fault_in high, or an enabled read parity error) while not stalled raises stall on the next cycle. While stall is high, rd0_ready and rd1_ready are low.
- R5: With esc_en=1 and mchk_en=1, a fault event yields mchk_req high for exactly one cycle, the cycle after the event.
- R6: With esc_en=1 and mchk_en=0, a fault event sets chkstop on the next cycle. chkstop and stall then stay high until reset, and int_ack has no effect on them.
- R7: With esc_en=0, a fault event sets stall only; mchk_req and chkstop stay low.
- R8: int_ack high while stalled and not checkstopped clears stall on the next cycle.
- R9: err_bus[k] is set when bus k has an enabled parity error. err_lanes ORs in the byte lanes that failed on either bus. Both are sticky until reset.
- R10: After reset: stall, mchk_req and chkstop are 0, err_bus and err_lanes are 0, and both ready outputs are 1.
- R11: A fault_in that arrives while already stalled starts no new escalation; in particular it produces no further mchk_req pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_chk_en | input | 2 | Parity check enable, bit k for read bus k |
| esc_en | input | 1 | Fault escalation enable |
| mchk_en | input | 1 | Machine-check enable (selects machine check over checkstop) |
| fault_in | input | 1 | External bus fault |
| int_ack | input | 1 | Interrupt acknowledge, releases a non-fatal stall |
| wr_data | input | DATA_W | Outgoing write data |
| wr_par | output | DATA_W/8 | Odd parity for each write byte lane |
| rd0_valid | input | 1 | Read bus 0 beat valid |
| rd0_ready | output | 1 | Read bus 0 ready (low while stalled) |
| rd0_data | input | DATA_W | Read bus 0 data |
| rd0_par | input | DATA_W/8 | Read bus 0 parity bits |
| rd1_valid | input | 1 | Read bus 1 beat valid |
| rd1_ready | output | 1 | Read bus 1 ready (low while stalled) |
| rd1_data | input | DATA_W | Read bus 1 data |
| rd1_par | input | DATA_W/8 | Read bus 1 parity bits |
| stall | output | 1 | Transaction stalled |
| mchk_req | output | 1 | One-cycle machine-check request |
| chkstop | output | 1 | Fatal checkstop, sticky until reset |
| err_bus | output | 2 | Sticky: bus k has seen a parity error |
| err_lanes | output | DATA_W/8 | Sticky: byte lanes that have failed |

## Verification
Write parity is tried with all-zero, all-one, mixed and walking-bit words. Together these separate correct odd parity from even parity and show whether lanes are swapped. Read beats with correct parity on an enabled bus show that good data raises nothing. Bad parity on a disabled bus shows that the two enables are independent. Corrupting chosen lanes (2 and 5 on bus 0, 7 on bus 1) shows that the lane and bus status lands in the right bit positions. The three settings of the escalation controls are applied in turn, together with faults while stalled and acknowledges after a checkstop, to tell the machine-check, checkstop and stall-only outcomes apart.

// File: rtl/bytepar_pkg.sv
package bytepar_pkg;
  localparam int NUM_RD = 2;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_MCHK    = 2'd1,
    ACT_CHKSTOP = 2'd2
  } esc_action_t;
endpackage

// File: rtl/lane_par_gen.sv
module lane_par_gen #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  output logic [LANES-1:0]        par
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = ~^data[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/rd_par_check.sv
module rd_par_check #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    beat,
  input  logic                    chk_en,
  input  logic [LANES*LANE_W-1:0] data,
  input  logic [LANES-1:0]        par,
  output logic [LANES-1:0]        lane_err
);
  logic [LANES-1:0] exp_par;

  lane_par_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen (
    .data (data),
    .par  (exp_par)
  );

  assign lane_err = (exp_par ^ par) & {LANES{beat & chk_en}};
endmodule

// File: rtl/fault_esc_ctrl.sv
module fault_esc_ctrl
  import bytepar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  input  logic esc_en,
  input  logic mchk_en,
  input  logic int_ack,
  output logic stall,
  output logic mchk_req,
  output logic chkstop
);
  esc_action_t action;
  logic        evt_take;

  assign evt_take = event_in & ~stall;

  always_comb begin
    if (!esc_en)      action = ACT_NONE;
    else if (mchk_en) action = ACT_MCHK;
    else              action = ACT_CHKSTOP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall    <= 1'b0;
      mchk_req <= 1'b0;
      chkstop  <= 1'b0;
    end else begin
      mchk_req <= 1'b0;
      if (evt_take) begin
        stall    <= 1'b1;
        mchk_req <= (action == ACT_MCHK);
        if (action == ACT_CHKSTOP) chkstop <= 1'b1;
      end else if (stall && int_ack && !chkstop) begin
        stall <= 1'b0;
      end
    end
  end

  AST_EVENT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && !stall) |=> stall); // R4
  AST_MCHK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_req |=> !mchk_req); // R5
  AST_MCHK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_req |-> $past(esc_en && mchk_en && event_in)); // R5
  AST_CHKSTOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chkstop |=> (chkstop && stall)); // R6
  AST_NO_ESC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && !stall && !esc_en) |=> (!mchk_req && !chkstop)); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && int_ack && !chkstop) |=> !stall); // R8
  AST_NO_REESCALATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> !mchk_req); // R11
endmodule

// File: rtl/bytepar_fault_unit.sv
module bytepar_fault_unit
  import bytepar_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_RD-1:0] rd_chk_en,
  input  logic              esc_en,
  input  logic              mchk_en,
  input  logic              fault_in,
  input  logic              int_ack,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_par,
  input  logic              rd0_valid,
  output logic              rd0_ready,
  input  logic [DATA_W-1:0] rd0_data,
  input  logic [LANES-1:0]  rd0_par,
  input  logic              rd1_valid,
  output logic              rd1_ready,
  input  logic [DATA_W-1:0] rd1_data,
  input  logic [LANES-1:0]  rd1_par,
  output logic              stall,
  output logic              mchk_req,
  output logic              chkstop,
  output logic [NUM_RD-1:0] err_bus,
  output logic [LANES-1:0]  err_lanes
);
  logic              rd_ready;
  logic [NUM_RD-1:0] rd_valid_a;
  logic [DATA_W-1:0] rd_data_a [NUM_RD];
  logic [LANES-1:0]  rd_par_a  [NUM_RD];
  logic [LANES-1:0]  lane_err_a [NUM_RD];
  logic [NUM_RD-1:0] bus_err;
  logic [LANES-1:0]  lane_or;
  logic              fault_evt;

  assign rd_valid_a   = {rd1_valid, rd0_valid};
  assign rd_data_a[0] = rd0_data;
  assign rd_data_a[1] = rd1_data;
  assign rd_par_a[0]  = rd0_par;
  assign rd_par_a[1]  = rd1_par;

  assign rd_ready  = ~stall;
  assign rd0_ready = rd_ready;
  assign rd1_ready = rd_ready;

  lane_par_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_gen (
    .data (wr_data),
    .par  (wr_par)
  );

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    rd_par_check #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
      .beat     (rd_valid_a[k] & rd_ready),
      .chk_en   (rd_chk_en[k]),
      .data     (rd_data_a[k]),
      .par      (rd_par_a[k]),
      .lane_err (lane_err_a[k])
    );
    assign bus_err[k] = |lane_err_a[k];
  end

  always_comb begin
    lane_or = '0;
    for (int k = 0; k < NUM_RD; k++) lane_or |= lane_err_a[k];
  end

  assign fault_evt = fault_in | (|bus_err);

  fault_esc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_in (fault_evt),
    .esc_en   (esc_en),
    .mchk_en  (mchk_en),
    .int_ack  (int_ack),
    .stall    (stall),
    .mchk_req (mchk_req),
    .chkstop  (chkstop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_bus   <= '0;
      err_lanes <= '0;
    end else begin
      err_bus   <= err_bus | bus_err;
      err_lanes <= err_lanes | lane_or;
    end
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((err_lanes & $past(err_lanes)) == $past(err_lanes)) &&
               ((err_bus & $past(err_bus)) == $past(err_bus)))); // R9
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chk_en == '0 && !fault_in && !stall) |=> !stall); // R3
endmodule

// File: tb/bytepar_fault_unit_test.sv
module bytepar_fault_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rd_chk_en = '0;
  logic        esc_en = 1'b0, mchk_en = 1'b0, fault_in = 1'b0, int_ack = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_par;
  logic        rd0_valid = 1'b0, rd1_valid = 1'b0, rd0_ready, rd1_ready;
  logic [63:0] rd0_data = '0, rd1_data = '0;
  logic [7:0]  rd0_par = '0, rd1_par = '0;
  logic        stall, mchk_req, chkstop;
  logic [1:0]  err_bus;
  logic [7:0]  err_lanes;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bytepar_fault_unit uut (
    .clk(clk), .rst_n(rst_n), .rd_chk_en(rd_chk_en), .esc_en(esc_en),
    .mchk_en(mchk_en), .fault_in(fault_in), .int_ack(int_ack),
    .wr_data(wr_data), .wr_par(wr_par),
    .rd0_valid(rd0_valid), .rd0_ready(rd0_ready), .rd0_data(rd0_data), .rd0_par(rd0_par),
    .rd1_valid(rd1_valid), .rd1_ready(rd1_ready), .rd1_data(rd1_data), .rd1_par(rd1_par),
    .stall(stall), .mchk_req(mchk_req), .chkstop(chkstop),
    .err_bus(err_bus), .err_lanes(err_lanes)
  );

  function automatic logic [7:0] odd_par(input logic [63:0] d);
    logic [7:0] p;
    for (int l = 0; l < 8; l++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(d[8*l+b]);
      p[l] = (ones % 2 == 0);
    end
    return p;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_fault();
    @(negedge clk) fault_in = 1'b1;
    @(negedge clk) fault_in = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) int_ack = 1'b1;
    @(negedge clk) int_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "stall", 64'(stall), 0);
    chk("R10", "mchk_req", 64'(mchk_req), 0);
    chk("R10", "chkstop", 64'(chkstop), 0);
    chk("R10", "err_bus", 64'(err_bus), 0);
    chk("R10", "err_lanes", 64'(err_lanes), 0);
    chk("R10", "ready", 64'({rd0_ready, rd1_ready}), 64'h3);
  endtask

  task automatic t_write();
    logic [63:0] pats [6];
    pats[0] = 64'h0;
    pats[1] = '1;
    pats[2] = 64'h0123456789ABCDEF;
    pats[3] = 64'h8040201008040201;
    pats[4] = 64'h0000000300000001;
    pats[5] = 64'hFE00000000000007;
    foreach (pats[i]) begin
      @(negedge clk) wr_data = pats[i];
      #1 chk("R1", "wr_par", 64'(wr_par), 64'(odd_par(pats[i])));
    end
  endtask

  task automatic t_rd_good();
    rd_chk_en = 2'b11;
    esc_en = 1'b1; mchk_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [63:0] d = 64'h1111111111111111 * 64'(i + 3) ^ {32'(i), 32'hA5A5_5A5A};
      @(negedge clk) rd0_valid = 1'b1; rd0_data = d; rd0_par = odd_par(d);
    end
    @(negedge clk) rd0_valid = 1'b0;
    @(negedge clk);
    chk("R2", "stall after good beats", 64'(stall), 0);
    chk("R2", "err_bus after good beats", 64'(err_bus), 0);
  endtask

  task automatic t_rd_disabled();
    rd_chk_en = 2'b01;
    @(negedge clk) rd1_valid = 1'b1; rd1_data = 64'hDEADBEEF_CAFEF00D;
    rd1_par = ~odd_par(rd1_data);
    @(negedge clk) rd1_valid = 1'b0;
    chk("R3", "stall on disabled bus", 64'(stall), 0);
    @(negedge clk);
    chk("R3", "err_bus on disabled bus", 64'(err_bus), 0);
    chk("R3", "err_lanes on disabled bus", 64'(err_lanes), 0);
  endtask

  task automatic t_rd_bad0();
    rd_chk_en = 2'b01;
    esc_en = 1'b0; mchk_en = 1'b0;
    @(negedge clk) rd0_valid = 1'b1; rd0_data = 64'h0F0F_3C3C_AAAA_5555;
    rd0_par = odd_par(rd0_data) ^ 8'h24;
    @(negedge clk) rd0_valid = 1'b0;
    chk("R2", "stall after bad bus0 beat", 64'(stall), 1);
    chk("R4", "rd0_ready while stalled", 64'(rd0_ready), 0);
    chk("R7", "mchk_req without escalation", 64'(mchk_req), 0);
    chk("R7", "chkstop without escalation", 64'(chkstop), 0);
    chk("R9", "err_bus bus0", 64'(err_bus), 64'h1);
    chk("R9", "err_lanes 2 and 5", 64'(err_lanes), 64'h24);
    esc_en = 1'b1; mchk_en = 1'b1;
    pulse_fault();
    chk("R11", "no mchk for fault while stalled", 64'(mchk_req), 0);
    chk("R11", "still stalled", 64'(stall), 1);
    pulse_ack();
    chk("R8", "stall cleared by ack", 64'(stall), 0);
    chk("R8", "ready back", 64'(rd0_ready), 1);
  endtask

  task automatic t_mchk();
    esc_en = 1'b1; mchk_en = 1'b1;
    pulse_fault();
    chk("R4", "stall after fault_in", 64'(stall), 1);
    chk("R5", "mchk_req pulse", 64'(mchk_req), 1);
    @(negedge clk);
    chk("R5", "mchk_req one cycle", 64'(mchk_req), 0);
    chk("R5", "no chkstop", 64'(chkstop), 0);
    pulse_ack();
    chk("R8", "stall cleared after mchk", 64'(stall), 0);
  endtask

  task automatic t_bad1();
    rd_chk_en = 2'b10;
    @(negedge clk) rd1_valid = 1'b1; rd1_data = 64'h8000_0000_0000_0000;
    rd1_par = odd_par(rd1_data) ^ 8'h80;
    @(negedge clk) rd1_valid = 1'b0;
    chk("R3", "bus1 enabled alone stalls", 64'(stall), 1);
    chk("R5", "mchk from bus1 parity", 64'(mchk_req), 1);
    chk("R9", "err_bus both sticky", 64'(err_bus), 64'h3);
    chk("R9", "err_lanes accumulate", 64'(err_lanes), 64'hA4);
    pulse_ack();
  endtask

  task automatic t_chkstop();
    esc_en = 1'b1; mchk_en = 1'b0;
    pulse_fault();
    chk("R6", "chkstop set", 64'(chkstop), 1);
    chk("R6", "no mchk on chkstop", 64'(mchk_req), 0);
    pulse_ack();
    chk("R6", "chkstop holds after ack", 64'(chkstop), 1);
    chk("R6", "stall holds after ack", 64'(stall), 1);
    do_reset();
    chk("R10", "chkstop cleared by reset", 64'(chkstop), 0);
    chk("R10", "status cleared by reset", 64'({err_bus, err_lanes}), 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_write();
    t_rd_good();
    t_rd_disabled();
    t_rd_bad0();
    t_mchk();
    t_bad1();
    t_chkstop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule